// File: doc/BRIEF.md
# Ethertype-Directed Header Parser

This block reads a packet one byte per accepted cycle and walks a fixed parse graph: an Ethernet header first, then optionally an 802.1Q-style VLAN tag, then optionally a four-hop source-routing tag. At each level the 16-bit type field chooses the next header, and type 0x0800 marks the start of an IPv4 header. The graph is held as a table of (state, type, next) edges in a package, so a new branch is one new table row.

Each completed header is written into a fixed slot of a 192-bit header vector and gets its own valid flag. Slots of headers that are not valid read as zero. When parsing ends, whether by reaching IPv4, by meeting a type the graph does not know, or by the packet ending early, a one-cycle done strobe is raised. The vector and flags then hold until the first byte of the next packet arrives. Any bytes left in the packet after that point are consumed and have no effect.

Top module: `hdr_parser`

## Requirements
- R1: After 14 bytes the Ethernet header is complete, `eth_ok` goes high, and `hdr_vec[191:144]` holds the destination address, `[143:96]` the source address and `[95:80]` the type. Every field is most significant byte first.
- R2: An Ethernet type of 0x8100 or 0x9100 leads to a 4-byte VLAN header. When complete, `vlan_ok` goes high and `hdr_vec[79:48]` holds it: priority in [79:77], drop flag in [76], VLAN id in [75:64] and inner type in [63:48].
- R3: A VLAN inner type of 0xAAAA leads to a 6-byte routing tag. When complete, `tag_ok` goes high and `hdr_vec[47:0]` holds up1 [47:40], up2 [39:32], down1 [31:24], down2 [23:16] and type [15:0].
- R4: A type of 0x0800 after the Ethernet, VLAN or routing-tag header sets `ipv4_ok` and ends parsing.
- R5: Any other type ends parsing with the headers already completed still flagged valid, and with `ipv4_ok` and `trunc_err` low. 0xAAAA directly after Ethernet and 0x8100 after a VLAN header are such types.
- R6: If `in_last` arrives before a needed header is complete, parsing ends with `trunc_err` high and that header not flagged valid. This includes the case where the packet ends exactly where the next header should begin.
- R7: `done` is high for exactly one cycle, in the cycle after the clock edge that accepts the byte that decides the end of parsing. Vector and flags are valid from that cycle on.
- R8: The slot of any header whose valid flag is low reads as all zeros.
- R9: `in_ready` is always high. Bytes after the end of parsing, up to and including `in_last`, leave the outputs unchanged, and the next byte starts a new packet at the Ethernet header.
- R10: A cycle with `in_valid` low changes no output and no parse progress.
- R11: After reset, the vector, all flags and `done` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_ready | output | 1 | Parser can take a byte (always high) |
| in_data | input | 8 | Packet byte |
| in_last | input | 1 | Byte is the last of its packet |
| hdr_vec | output | 192 | Header vector: Ethernet, VLAN and routing-tag slots |
| eth_ok | output | 1 | Ethernet slot valid |
| vlan_ok | output | 1 | VLAN slot valid |
| tag_ok | output | 1 | Routing-tag slot valid |
| ipv4_ok | output | 1 | IPv4 header follows the parsed headers |
| trunc_err | output | 1 | Packet ended inside a needed header |
| done | output | 1 | One-cycle end-of-parse strobe |

## Verification
The hardest outcome to reach from the ports is a truncation that lands exactly on a header boundary. It needs a packet whose length equals the bytes parsed so far and whose last type field asks for one more header, for example 14 bytes with type 0x9100. Random packets seldom hit this case, so the stimulus pairs directed boundary packets with random ones. The random packets draw their type fields from a short list weighted toward graph edges and use lengths from 1 to 40 bytes, so all three levels and both ways of ending recur often. Random idle cycles between bytes test that stalls have no effect, and the trailing payload tests that bytes after the end of parsing are ignored.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int BYTE_W     = 8;
  localparam int ETH_BYTES  = 14;
  localparam int VLAN_BYTES = 4;
  localparam int TAG_BYTES  = 6;
  localparam int ETH_W      = ETH_BYTES * BYTE_W;
  localparam int VLAN_W     = VLAN_BYTES * BYTE_W;
  localparam int TAG_W      = TAG_BYTES * BYTE_W;
  localparam int VEC_W      = ETH_W + VLAN_W + TAG_W;
  localparam int CNT_W      = $clog2(ETH_BYTES);
  localparam int TYPE_W     = 16;

  typedef enum logic [1:0] {ST_ETH, ST_VLAN, ST_TAG, ST_SKIP} pstate_e;
  typedef enum logic [1:0] {NX_VLAN, NX_TAG, NX_IPV4, NX_END} pnext_e;

  typedef struct packed {
    pstate_e             from;
    logic [TYPE_W-1:0]   etype;
    pnext_e              to;
  } graph_edge_t;

  localparam int N_EDGES = 6;
  localparam graph_edge_t GRAPH [N_EDGES] = '{
    '{ST_ETH,  16'h8100, NX_VLAN},
    '{ST_ETH,  16'h9100, NX_VLAN},
    '{ST_ETH,  16'h0800, NX_IPV4},
    '{ST_VLAN, 16'hAAAA, NX_TAG},
    '{ST_VLAN, 16'h0800, NX_IPV4},
    '{ST_TAG,  16'h0800, NX_IPV4}
  };
endpackage

// File: rtl/hp_field_shift.sv
module hp_field_shift #(
  parameter int NBYTES = 4,
  parameter int BW     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [BW-1:0]        din,
  output logic [NBYTES*BW-1:0] q
);
  localparam int W = NBYTES * BW;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (en) q <= {q[W-BW-1:0], din};
  end
endmodule

// File: rtl/hp_graph.sv
module hp_graph
  import hp_pkg::*;
(
  input  pstate_e           cur,
  input  logic [TYPE_W-1:0] etype,
  output pnext_e            nxt
);
  always_comb begin
    nxt = NX_END;
    for (int i = 0; i < N_EDGES; i++) begin
      if (GRAPH[i].from == cur && GRAPH[i].etype == etype) nxt = GRAPH[i].to;
    end
  end
endmodule

// File: rtl/hdr_parser.sv
module hdr_parser
  import hp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic             in_last,
  output logic [VEC_W-1:0] hdr_vec,
  output logic             eth_ok,
  output logic             vlan_ok,
  output logic             tag_ok,
  output logic             ipv4_ok,
  output logic             trunc_err,
  output logic             done
);
  pstate_e           st;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  last_idx;
  logic [BYTE_W-1:0] prev_byte;
  logic [ETH_W-1:0]  eth_q;
  logic [VLAN_W-1:0] vlan_q;
  logic [TAG_W-1:0]  tag_q;
  pnext_e            nxt;
  logic              start;
  logic              hdr_end;

  assign in_ready = 1'b1;
  assign start    = (st == ST_ETH) && (cnt == '0);
  assign hdr_end  = in_valid && (st != ST_SKIP) && (cnt == last_idx);

  always_comb begin
    case (st)
      ST_VLAN: last_idx = CNT_W'(VLAN_BYTES - 1);
      ST_TAG:  last_idx = CNT_W'(TAG_BYTES - 1);
      default: last_idx = CNT_W'(ETH_BYTES - 1);
    endcase
  end

  hp_graph graph_i (.cur(st), .etype({prev_byte, in_data}), .nxt(nxt));

  hp_field_shift #(.NBYTES(ETH_BYTES), .BW(BYTE_W)) eth_sh_i (
    .clk(clk), .rst(rst), .en(in_valid && st == ST_ETH), .din(in_data), .q(eth_q));
  hp_field_shift #(.NBYTES(VLAN_BYTES), .BW(BYTE_W)) vlan_sh_i (
    .clk(clk), .rst(rst), .en(in_valid && st == ST_VLAN), .din(in_data), .q(vlan_q));
  hp_field_shift #(.NBYTES(TAG_BYTES), .BW(BYTE_W)) tag_sh_i (
    .clk(clk), .rst(rst), .en(in_valid && st == ST_TAG), .din(in_data), .q(tag_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_ETH;
      cnt       <= '0;
      prev_byte <= '0;
      eth_ok    <= 1'b0;
      vlan_ok   <= 1'b0;
      tag_ok    <= 1'b0;
      ipv4_ok   <= 1'b0;
      trunc_err <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (in_valid) begin
        prev_byte <= in_data;
        if (start) begin
          eth_ok    <= 1'b0;
          vlan_ok   <= 1'b0;
          tag_ok    <= 1'b0;
          ipv4_ok   <= 1'b0;
          trunc_err <= 1'b0;
        end
        if (st == ST_SKIP) begin
          if (in_last) st <= ST_ETH;
        end else if (hdr_end) begin
          cnt <= '0;
          case (st)
            ST_ETH:  eth_ok  <= 1'b1;
            ST_VLAN: vlan_ok <= 1'b1;
            default: tag_ok  <= 1'b1;
          endcase
          case (nxt)
            NX_VLAN, NX_TAG: begin
              if (in_last) begin
                trunc_err <= 1'b1;
                done      <= 1'b1;
                st        <= ST_ETH;
              end else begin
                st <= (nxt == NX_VLAN) ? ST_VLAN : ST_TAG;
              end
            end
            NX_IPV4: begin
              ipv4_ok <= 1'b1;
              done    <= 1'b1;
              st      <= in_last ? ST_ETH : ST_SKIP;
            end
            default: begin
              done <= 1'b1;
              st   <= in_last ? ST_ETH : ST_SKIP;
            end
          endcase
        end else if (in_last) begin
          trunc_err <= 1'b1;
          done      <= 1'b1;
          st        <= ST_ETH;
          cnt       <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign hdr_vec = {eth_q & {ETH_W{eth_ok}},
                    vlan_q & {VLAN_W{vlan_ok}},
                    tag_q & {TAG_W{tag_ok}}};
endmodule

// File: rtl/hp_checker.sv
module hp_checker
  import hp_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [VEC_W-1:0] hdr_vec,
  input logic             eth_ok,
  input logic             vlan_ok,
  input logic             tag_ok,
  input logic             ipv4_ok,
  input logic             trunc_err,
  input logic             done
);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(hdr_vec) && $stable({eth_ok, vlan_ok, tag_ok, ipv4_ok, trunc_err}) && !done);

  p_vlan_needs_eth_r2: assert property (@(posedge clk) disable iff (rst)
    vlan_ok |-> eth_ok);

  p_tag_needs_vlan_r3: assert property (@(posedge clk) disable iff (rst)
    tag_ok |-> vlan_ok && eth_ok);

  p_ipv4_with_done_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ipv4_ok) |-> done);

  p_trunc_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(trunc_err && ipv4_ok));
endmodule

bind hdr_parser hp_checker chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .hdr_vec(hdr_vec),
  .eth_ok(eth_ok), .vlan_ok(vlan_ok), .tag_ok(tag_ok),
  .ipv4_ok(ipv4_ok), .trunc_err(trunc_err), .done(done));

// File: tb/hdr_parser_tb_top.sv
module hdr_parser_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 192;
  localparam int MAXB = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = '0;
  logic in_last = 1'b0;
  logic [VW-1:0] hdr_vec;
  logic eth_ok, vlan_ok, tag_ok, ipv4_ok, trunc_err, done;

  int checks = 0;
  int errors = 0;
  logic [7:0] pkt [MAXB];

  always #(CLK_PERIOD/2) clk = ~clk;

  hdr_parser dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .hdr_vec(hdr_vec),
    .eth_ok(eth_ok), .vlan_ok(vlan_ok), .tag_ok(tag_ok),
    .ipv4_ok(ipv4_ok), .trunc_err(trunc_err), .done(done));

  task automatic check(input bit ok, input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pick_type();
    case ($urandom_range(0, 5))
      0, 5:    return 16'h0800;
      1:       return 16'h8100;
      2:       return 16'h9100;
      3:       return 16'hAAAA;
      default: return 16'($urandom());
    endcase
  endfunction

  task automatic build(input logic [15:0] t0, input logic [15:0] t1, input logic [15:0] t2);
    for (int i = 0; i < MAXB; i++) pkt[i] = 8'($urandom());
    pkt[12] = t0[15:8]; pkt[13] = t0[7:0];
    pkt[16] = t1[15:8]; pkt[17] = t1[7:0];
    pkt[22] = t2[15:8]; pkt[23] = t2[7:0];
  endtask

  task automatic model(input int n, output logic [VW-1:0] ev, output logic [4:0] ef, output int dec);
    int pos, lvl, hl, top;
    bit go;
    logic [15:0] t;
    logic e_eth, e_vlan, e_tag, e_ip, e_tr;
    ev = '0; e_eth = 0; e_vlan = 0; e_tag = 0; e_ip = 0; e_tr = 0;
    pos = 0; lvl = 0; go = 1; dec = n - 1;
    while (go) begin
      hl  = (lvl == 0) ? 14 : (lvl == 1) ? 4 : 6;
      top = (lvl == 0) ? 191 : (lvl == 1) ? 79 : 47;
      if (pos + hl > n) begin
        e_tr = 1; dec = n - 1; go = 0;
      end else begin
        for (int i = 0; i < hl; i++) ev[top - 8*i -: 8] = pkt[pos + i];
        if (lvl == 0) e_eth = 1; else if (lvl == 1) e_vlan = 1; else e_tag = 1;
        t = {pkt[pos + hl - 2], pkt[pos + hl - 1]};
        pos = pos + hl;
        dec = pos - 1;
        if (t == 16'h0800) begin e_ip = 1; go = 0; end
        else if (lvl == 0 && (t == 16'h8100 || t == 16'h9100)) lvl = 1;
        else if (lvl == 1 && t == 16'hAAAA) lvl = 2;
        else go = 0;
      end
    end
    ef = {e_eth, e_vlan, e_tag, e_ip, e_tr};
  endtask

  task automatic run_pkt(input int n, input bit gaps);
    logic [VW-1:0] ev, snap_v;
    logic [4:0] ef, snap_f;
    int dec, dcount, didx;
    model(n, ev, ef, dec);
    dcount = 0; didx = -1; snap_v = '0; snap_f = '0;
    for (int i = 0; i < n; i++) begin
      while (gaps && $urandom_range(0, 3) == 0) begin
        @(negedge clk); in_valid = 1'b0;
        @(posedge clk); #1;
        if (done) dcount++;
      end
      @(negedge clk);
      in_valid = 1'b1; in_data = pkt[i]; in_last = (i == n - 1);
      @(posedge clk); #1;
      if (done) begin
        dcount++; didx = i;
        snap_v = hdr_vec;
        snap_f = {eth_ok, vlan_ok, tag_ok, ipv4_ok, trunc_err};
      end
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    check(dcount == 1, "R7 done count", VW'(dcount), VW'(1));
    check(didx == dec, "R7 done cycle", VW'(didx), VW'(dec));
    check(snap_v[191:80] == ev[191:80], "R1 R8 ethernet slot", VW'(snap_v[191:80]), VW'(ev[191:80]));
    check(snap_v[79:48] == ev[79:48], "R2 R8 vlan slot", VW'(snap_v[79:48]), VW'(ev[79:48]));
    check(snap_v[47:0] == ev[47:0], "R3 R8 tag slot", VW'(snap_v[47:0]), VW'(ev[47:0]));
    check(snap_f[4:2] == ef[4:2], "R5 header valid flags", VW'(snap_f[4:2]), VW'(ef[4:2]));
    check(snap_f[1] == ef[1], "R4 ipv4 flag", VW'(snap_f[1]), VW'(ef[1]));
    check(snap_f[0] == ef[0], "R6 truncation flag", VW'(snap_f[0]), VW'(ef[0]));
    check(hdr_vec == snap_v && {eth_ok, vlan_ok, tag_ok, ipv4_ok, trunc_err} == snap_f,
          "R9 trailing bytes ignored", hdr_vec, snap_v);
    repeat (3) @(posedge clk);
    #1;
    check(hdr_vec == snap_v && !done, "R10 idle hold", hdr_vec, snap_v);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check(hdr_vec == '0, "R11 reset vector", hdr_vec, '0);
    check({eth_ok, vlan_ok, tag_ok, ipv4_ok, trunc_err, done} == '0, "R11 reset flags",
          VW'({eth_ok, vlan_ok, tag_ok, ipv4_ok, trunc_err, done}), '0);
    check(in_ready == 1'b1, "R9 ready high", VW'(in_ready), VW'(1));

    build(16'h0800, 16'h0, 16'h0);        run_pkt(14, 0); // R4 at Ethernet level, exact length
    build(16'h8100, 16'hAAAA, 16'h0800);  run_pkt(40, 1); // R3 full stack then IPv4
    build(16'h9100, 16'h0800, 16'h0);     run_pkt(30, 0); // R2 second VLAN type
    build(16'h0800, 16'h0, 16'h0);        run_pkt(1, 0);  // R6 one-byte packet
    build(16'h9100, 16'h0, 16'h0);        run_pkt(14, 0); // R6 ends on header boundary
    build(16'h8100, 16'hAAAA, 16'h0);     run_pkt(20, 1); // R6 inside routing tag
    build(16'hAAAA, 16'h0800, 16'h0);     run_pkt(20, 0); // R5 tag type right after Ethernet
    build(16'h8100, 16'h8100, 16'h0);     run_pkt(25, 1); // R5 nested VLAN type not in graph
    build(16'h8100, 16'hAAAA, 16'h1234);  run_pkt(24, 0); // R5 unknown after tag

    for (int k = 0; k < 300; k++) begin
      build(pick_type(), pick_type(), pick_type());
      run_pkt($urandom_range(1, 40), 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule